// File: doc/BRIEF.md
# DRAM Refresh Debt Scheduler

This block sits beside the command scheduler of a DDR SDRAM controller and decides when an AUTO REFRESH is owed. A free-running interval timer counts down one average refresh period, given in controller clock cycles, and produces a single-cycle tick each time the period elapses. Every tick adds one to a debt counter. The scheduler may postpone refreshes while it is busy with other traffic. The debt stops growing at eight, and at that level an urgent request tells the scheduler that it must issue a refresh before any other command.

When the scheduler issues a refresh, it pulses a strobe for one cycle. The block accepts the strobe only when refreshes are owed and no earlier refresh is still recovering. An accepted strobe lowers the debt by one and starts the recovery window (tRFC). Through that window the block asserts a busy output, which stops every other command, and a clock-enable hold output, which keeps CKE high on every edge. The timer input stays low until device initialisation is complete. While it is low, the timer keeps its current count.

The recovery controller has two states. In `RF_IDLE` there is no refresh in flight. The transition *accept* (strobe with debt nonzero) moves it to `RF_RECOVER` and loads the recovery counter. In `RF_RECOVER` the counter steps down once per cycle. The transition *expire* (counter at zero) returns it to `RF_IDLE`.

Top module: `refresh_sched`

## Requirements
- R1: After reset, debt is 0 and ref_req, ref_urgent, ref_busy and cke_hold are all low.
- R2: While timer_en is high, one tick is produced every INTERVAL_CYCLES cycles, and each tick raises the debt by one, visible the cycle after the tick. While timer_en is low, no tick occurs and the timer holds its count.
- R3: The debt never exceeds DEBT_MAX (8). A tick at DEBT_MAX with no accepted strobe leaves it at DEBT_MAX.
- R4: ref_req is high exactly when the debt is nonzero and ref_busy is low.
- R5: ref_urgent is high exactly when the debt equals DEBT_MAX and ref_busy is low.
- R6: A strobe on ref_issued is accepted when the debt is nonzero and ref_busy is low. After acceptance the debt falls by one on the next cycle, and ref_busy is high for exactly TRFC_CYCLES cycles starting on the next cycle.
- R7: cke_hold is high in the cycle of an accepted strobe and in every cycle where ref_busy is high, and low otherwise.
- R8: A strobe while ref_busy is high, or while the debt is 0, is ignored. The debt is unchanged and the recovery window is neither started nor restarted.
- R9: When a tick and an accepted strobe fall in the same cycle, the debt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_en | input | 1 | Lets the interval timer run once initialisation is done |
| ref_issued | input | 1 | One-cycle strobe: the scheduler has issued AUTO REFRESH |
| ref_req | output | 1 | One or more refreshes are owed and one may be issued now |
| ref_urgent | output | 1 | Debt at its cap; a refresh must go before any other command |
| ref_busy | output | 1 | Refresh recovery in progress; block all other commands |
| cke_hold | output | 1 | Force clock enable high |
| ref_debt | output | 4 | Number of refreshes currently owed |

## Verification
The main debt function is exercised with four patterns:
- A stopped timer, which shows that a paused count does not drift.
- A plain run of ticks, which shows the tick spacing.
- A long run with no strobes, which drives the debt into saturation and raises the urgent request.
- Strobes timed against the tick, which distinguish a plain decrement from the same-cycle cancellation.

Strobes are also sent while recovery is in progress and while the debt is zero. These show that an ignored strobe leaves both the debt and the busy window untouched, as distinct from restarting them.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [0:0] {
        RF_IDLE    = 1'b0,
        RF_RECOVER = 1'b1
    } rf_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL_CYCLES = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= RELOAD;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb tick = run && (cnt_q == '0);

    // tick reloads the full interval
    assert_tick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == RELOAD);
    // paused timer keeps its count
    assert_pause_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
    parameter int DEBT_MAX = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          take,
    output logic [$clog2(DEBT_MAX+1)-1:0] debt,
    output logic                          owed,
    output logic                          full
);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    logic [DW-1:0] debt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else if (tick && !take) begin
            if (debt_q != CAP) debt_q <= debt_q + DW'(1);
        end else if (take && !tick) begin
            debt_q <= debt_q - DW'(1);
        end
    end

    always_comb begin
        debt = debt_q;
        owed = (debt_q != '0);
        full = (debt_q == CAP);
    end

    assert_debt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= CAP);
    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !take && debt_q == CAP) |=> debt_q == CAP);
    assert_take_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !tick) |=> debt_q == $past(debt_q) - DW'(1));
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !tick) |=> debt_q == $past(debt_q));
    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tick) |=> debt_q == $past(debt_q));
endmodule

// File: rtl/refresh_recovery_fsm.sv
module refresh_recovery_fsm
    import refresh_pkg::*;
#(
    parameter int TRFC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issued,
    input  logic owed,
    output logic accept,
    output logic busy,
    output logic cke_hold
);
    localparam int CW = (TRFC_CYCLES > 1) ? $clog2(TRFC_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_INIT = CW'(TRFC_CYCLES - 1);

    rf_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RF_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RF_IDLE: begin
                if (accept) begin
                    state_d = RF_RECOVER;
                    cnt_d   = CNT_INIT;
                end
            end
            RF_RECOVER: begin
                if (cnt_q == '0) state_d = RF_IDLE;
                else             cnt_d   = cnt_q - CW'(1);
            end
            default: state_d = RF_IDLE;
        endcase
    end

    always_comb begin
        accept   = (state_q == RF_IDLE) && issued && owed;
        busy     = (state_q == RF_RECOVER);
        cke_hold = busy || accept;
    end

    assert_accept_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && cnt_q == CNT_INIT));
    assert_window_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> busy);
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));
    assert_cke_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cke_hold);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int INTERVAL_CYCLES = 781,
    parameter int TRFC_CYCLES     = 8,
    parameter int DEBT_MAX        = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          timer_en,
    input  logic                          ref_issued,
    output logic                          ref_req,
    output logic                          ref_urgent,
    output logic                          ref_busy,
    output logic                          cke_hold,
    output logic [$clog2(DEBT_MAX+1)-1:0] ref_debt
);
    logic tick, accept, owed, full, busy;

    refresh_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_en), .tick(tick)
    );

    refresh_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .take(accept),
        .debt(ref_debt), .owed(owed), .full(full)
    );

    refresh_recovery_fsm #(.TRFC_CYCLES(TRFC_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .issued(ref_issued), .owed(owed),
        .accept(accept), .busy(busy), .cke_hold(cke_hold)
    );

    always_comb begin
        ref_busy   = busy;
        ref_req    = owed && !busy;
        ref_urgent = full && !busy;
    end

    assert_urgent_implies_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);
    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> (!ref_req && !ref_urgent));
endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int IV   = 10;
    localparam int TRFC = 4;
    localparam int DMAX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic timer_en = 1'b0;
    logic ref_issued = 1'b0;
    logic ref_req, ref_urgent, ref_busy, cke_hold;
    logic [3:0] ref_debt;

    always #5 clk = ~clk;

    refresh_sched #(.INTERVAL_CYCLES(IV), .TRFC_CYCLES(TRFC), .DEBT_MAX(DMAX)) uut (
        .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .ref_issued(ref_issued),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
        .cke_hold(cke_hold), .ref_debt(ref_debt)
    );

    typedef struct {
        string    tag;
        int       debt;
        bit       busy, req, urg, cke;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_timer, m_debt, m_busy;

    task automatic check_item(exp_t e);
        checks++;
        if (int'(ref_debt) != e.debt || ref_busy !== e.busy || ref_req !== e.req ||
            ref_urgent !== e.urg || cke_hold !== e.cke) begin
            fails++;
            $display("FAIL %s: got debt=%0d busy=%b req=%b urg=%b cke=%b expected debt=%0d busy=%b req=%b urg=%b cke=%b",
                     e.tag, ref_debt, ref_busy, ref_req, ref_urgent, cke_hold,
                     e.debt, e.busy, e.req, e.urg, e.cke);
        end
    endtask

    // driver: one cycle of stimulus plus its expected outputs
    task automatic step(input bit en, input bit iss, input string tag);
        exp_t e;
        bit busy, acc, tk;
        @(negedge clk);
        #1;
        timer_en   = en;
        ref_issued = iss;
        busy   = (m_busy > 0);
        acc    = iss && !busy && (m_debt != 0);
        tk     = en && (m_timer == 0);
        e.tag  = tag;
        e.debt = m_debt;
        e.busy = busy;
        e.req  = (m_debt != 0) && !busy;
        e.urg  = (m_debt == DMAX) && !busy;
        e.cke  = busy || acc;
        q.push_back(e);
        @(posedge clk);
        if (en) m_timer = (m_timer == 0) ? IV - 1 : m_timer - 1;
        if (tk && !acc) begin
            if (m_debt < DMAX) m_debt++;
        end else if (acc && !tk) begin
            m_debt--;
        end
        if (acc) m_busy = TRFC;
        else if (m_busy > 0) m_busy--;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) check_item(q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        m_timer = IV - 1;
        m_debt  = 0;
        m_busy  = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        checks++;
        if (ref_debt !== 4'd0 || ref_req !== 1'b0 || ref_urgent !== 1'b0 ||
            ref_busy !== 1'b0 || cke_hold !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got debt=%0d req=%b urg=%b busy=%b cke=%b expected all zero",
                     ref_debt, ref_req, ref_urgent, ref_busy, cke_hold);
        end
        #1 rst_n = 1'b1;

        // R2: paused timer produces no debt
        for (int i = 0; i < 15; i++) step(0, 0, "R2 paused");
        // R2/R4: two ticks accumulate
        for (int i = 0; i < 25; i++) step(1, 0, "R2 R4 ticks");
        // R6/R7: accepted strobe, then R8: strobes during recovery
        step(1, 1, "R6 R7 accept");
        for (int i = 0; i < TRFC + 2; i++) step(1, i < 3, "R8 strobe while busy");
        // drain debt, then R8: strobe with zero debt
        while (m_debt != 0) begin
            step(1, (m_busy == 0) && (m_timer > 1), "R6 drain");
        end
        for (int i = 0; i < 3; i++) step(1, 1, "R8 zero debt");
        // R3/R5: long run to saturation
        for (int i = 0; i < 12 * IV; i++) step(1, 0, "R3 R5 saturate");
        step(1, 1, "R5 R6 urgent serviced");
        for (int i = 0; i < TRFC + 2; i++) step(1, 0, "R4 R7 recovery");
        // R9: strobe aligned with a tick
        while (m_timer != 0) step(1, 0, "R9 align");
        step(1, 1, "R9 tick and accept");
        for (int i = 0; i < TRFC + 3; i++) step(1, 0, "R9 after");
        // R2: pause mid-interval then resume
        for (int i = 0; i < 7; i++) step(0, 0, "R2 pause mid");
        for (int i = 0; i < 2 * IV; i++) step(1, 0, "R2 resume");

        @(negedge clk);
        #3;
        finish_run();
    end
endmodule